// File: doc/BRIEF.md
# Reservation Monitor for Linked Load / Conditional Store

This block tracks address reservations for linked-load / conditional-store sequences. It also sends the queue hold and release commands that bracket an atomic read-modify-write pair. The monitor sits next to a cache controller and watches one completion per cycle. A completion is a strobe that carries a kind code, a line address and the number of the requester that made the access.

Each requester owns one reservation slot. A slot holds a valid flag and a line address. A linked load fills the slot. A conditional store tests the slot and then wipes every reservation on its line, whether the test passed or failed. Ordinary stores and atomic halves wipe the issuing requester's own reservation when the lines match.

One cycle after each completion, the monitor returns a result flag to the processor. In the same cycle it may send the controller a single-cycle hold or release command, together with the line it applies to.

Top module: `rsv_monitor`

## Requirements
- R1: A linked load (kind 3) by requester Q on line L records a reservation for Q on L. A later conditional store by Q on L reports pass (respPass=1).
- R2: A conditional store (kind 4) passes only when the issuing requester holds a valid reservation on exactly that line. A reservation held by another requester, or a reservation on another line, gives respPass=0.
- R3: Every conditional store clears all reservations on its line, whatever its result. Reservations on other lines are kept.
- R4: A plain store (kind 0), an atomic read (kind 1) or an atomic write (kind 2) by requester Q on line L clears Q's reservation if that reservation is on L. Reservations of other requesters, and Q's reservation on a different line, are kept.
- R5: Every completion that is not a conditional store reports respPass=1.
- R6: An atomic read completion raises blockReq, and an atomic write completion raises unblockReq. Each is a one-cycle pulse, with ctrlLine equal to the completion's line.
- R7: A new linked load by a requester replaces that requester's earlier reservation.
- R8: respValid is high for exactly the one cycle after a strobe with a kind from 0 to 4. Kinds 5 to 7 produce no response, no command and no change to any reservation.
- R9: Reset clears every reservation and drives respValid, blockReq and unblockReq low. A conditional store with no earlier linked load fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| doneValid | input | 1 | Completion strobe |
| doneKind | input | 3 | Kind: 0 store, 1 atomic read, 2 atomic write, 3 linked load, 4 conditional store |
| doneLine | input | LINE_W | Line address of the completion |
| doneReq | input | REQ_W | Requester number |
| respValid | output | 1 | Result valid, one cycle after the strobe |
| respPass | output | 1 | 1 = success, 0 = conditional store failed |
| blockReq | output | 1 | Hold the controller queue for ctrlLine |
| unblockReq | output | 1 | Release the controller queue for ctrlLine |
| ctrlLine | output | LINE_W | Line for the current response or command |

## Verification
The bound checker watches four things on every cycle:
- response timing against the strobe one cycle earlier;
- the source kind and line of each hold or release pulse;
- that a fail result only ever follows a conditional store;
- the two adjacent-pair cases: a linked load followed at once by a matching conditional store passes, and two matching conditional stores back to back fail on the second.

Only the bench scenarios can show reservations that live across idle gaps. These include whether another requester's store leaves a reservation alone, replacement by a second linked load, and the fact that reserved kind codes leave the state untouched.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [2:0] {
    KIND_STORE  = 3'd0,
    KIND_RMW_RD = 3'd1,
    KIND_RMW_WR = 3'd2,
    KIND_LL     = 3'd3,
    KIND_SC     = 3'd4
  } kind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic respond;   // produce a response next cycle
    logic setRes;    // fill the requester's slot
    logic checkSc;   // evaluate a conditional store
    logic clrLine;   // clear every slot on the line
    logic clrOwn;    // clear the requester's slot if the line matches
    logic blk;       // queue hold pulse
    logic unblk;     // queue release pulse
  } strobes_t;
endpackage

// File: rtl/rsv_ctrl.sv
module rsv_ctrl
  import rsv_pkg::*;
(
  input  logic       doneValid,
  input  logic [2:0] doneKind,
  output strobes_t   stb
);
  always_comb begin
    stb = '0;
    if (doneValid) begin
      unique case (doneKind)
        KIND_STORE:  begin stb.respond = 1'b1; stb.clrOwn = 1'b1; end
        KIND_RMW_RD: begin stb.respond = 1'b1; stb.clrOwn = 1'b1; stb.blk = 1'b1; end
        KIND_RMW_WR: begin stb.respond = 1'b1; stb.clrOwn = 1'b1; stb.unblk = 1'b1; end
        KIND_LL:     begin stb.respond = 1'b1; stb.setRes = 1'b1; end
        KIND_SC:     begin stb.respond = 1'b1; stb.checkSc = 1'b1; stb.clrLine = 1'b1; end
        default:     stb = '0;
      endcase
    end
  end
endmodule

// File: rtl/rsv_store.sv
module rsv_store
  import rsv_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int LINE_W  = 26,
  localparam int REQ_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          stb,
  input  logic [LINE_W-1:0] doneLine,
  input  logic [REQ_W-1:0]  doneReq,
  output logic              respValid,
  output logic              respPass,
  output logic              blockReq,
  output logic              unblockReq,
  output logic [LINE_W-1:0] ctrlLine
);
  logic [NUM_REQ-1:0] slotValid;
  logic [LINE_W-1:0]  slotLine [NUM_REQ];
  logic [NUM_REQ-1:0] lineHit;
  logic [NUM_REQ-1:0] isOwner;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
    assign isOwner[i] = (doneReq == REQ_W'(i));
    assign lineHit[i] = slotValid[i] && (slotLine[i] == doneLine);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slotValid[i] <= 1'b0;
        slotLine[i]  <= '0;
      end else if (stb.setRes && isOwner[i]) begin
        slotValid[i] <= 1'b1;
        slotLine[i]  <= doneLine;
      end else if (lineHit[i] && (stb.clrLine || (stb.clrOwn && isOwner[i]))) begin
        slotValid[i] <= 1'b0;
      end
    end
  end

  logic scHit;
  assign scHit = |(lineHit & isOwner);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      respValid  <= 1'b0;
      respPass   <= 1'b0;
      blockReq   <= 1'b0;
      unblockReq <= 1'b0;
      ctrlLine   <= '0;
    end else begin
      respValid  <= stb.respond;
      respPass   <= stb.respond && (!stb.checkSc || scHit);
      blockReq   <= stb.blk;
      unblockReq <= stb.unblk;
      if (stb.respond) ctrlLine <= doneLine;
    end
  end
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
  import rsv_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int LINE_W  = 26,
  localparam int REQ_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              doneValid,
  input  logic [2:0]        doneKind,
  input  logic [LINE_W-1:0] doneLine,
  input  logic [REQ_W-1:0]  doneReq,
  output logic              respValid,
  output logic              respPass,
  output logic              blockReq,
  output logic              unblockReq,
  output logic [LINE_W-1:0] ctrlLine
);
  strobes_t stb;

  rsv_ctrl u_ctrl (
    .doneValid (doneValid),
    .doneKind  (doneKind),
    .stb       (stb)
  );

  rsv_store #(.NUM_REQ(NUM_REQ), .LINE_W(LINE_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .doneLine   (doneLine),
    .doneReq    (doneReq),
    .respValid  (respValid),
    .respPass   (respPass),
    .blockReq   (blockReq),
    .unblockReq (unblockReq),
    .ctrlLine   (ctrlLine)
  );
endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk #(
  parameter int NUM_REQ = 4,
  parameter int LINE_W  = 26,
  localparam int REQ_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              doneValid,
  input logic [2:0]        doneKind,
  input logic [LINE_W-1:0] doneLine,
  input logic [REQ_W-1:0]  doneReq,
  input logic              respValid,
  input logic              respPass,
  input logic              blockReq,
  input logic              unblockReq,
  input logic [LINE_W-1:0] ctrlLine
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_resp_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1) |-> (respValid == ($past(doneValid) && ($past(doneKind) <= 3'd4))));

  assert_block_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && blockReq) |-> ($past(doneValid) && $past(doneKind) == 3'd1
                                    && ctrlLine == $past(doneLine) && !unblockReq));

  assert_unblock_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && unblockReq) |-> ($past(doneValid) && $past(doneKind) == 3'd2
                                      && ctrlLine == $past(doneLine)));

  assert_fail_only_sc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && respValid && !respPass) |-> ($past(doneKind) == 3'd4));

  assert_ll_then_sc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(doneValid) && $past(doneKind) == 3'd4
     && $past(doneValid, 2) && $past(doneKind, 2) == 3'd3
     && $past(doneReq, 2) == $past(doneReq) && $past(doneLine, 2) == $past(doneLine))
    |-> respPass);

  assert_sc_twice_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(doneValid) && $past(doneKind) == 3'd4
     && $past(doneValid, 2) && $past(doneKind, 2) == 3'd4
     && $past(doneLine, 2) == $past(doneLine))
    |-> !respPass);
endmodule

bind rsv_monitor rsv_monitor_chk #(.NUM_REQ(NUM_REQ), .LINE_W(LINE_W)) u_chk (.*);

// File: tb/rsv_monitor_bench.sv
`timescale 1ns/1ps
module rsv_monitor_bench;
  localparam int NUM_REQ = 4;
  localparam int LINE_W  = 26;
  localparam int REQ_W   = 2;
  localparam logic [LINE_W-1:0] LA = 26'h0000100;
  localparam logic [LINE_W-1:0] LB = 26'h0000200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic doneValid = 1'b0;
  logic [2:0] doneKind = '0;
  logic [LINE_W-1:0] doneLine = '0;
  logic [REQ_W-1:0] doneReq = '0;
  logic respValid, respPass, blockReq, unblockReq;
  logic [LINE_W-1:0] ctrlLine;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rsv_monitor #(.NUM_REQ(NUM_REQ), .LINE_W(LINE_W)) u_rsv_monitor (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One completion; returns at the next falling edge with the response visible
  task automatic issue(input logic [2:0] k, input logic [LINE_W-1:0] ln, input logic [REQ_W-1:0] q);
    @(negedge clk);
    doneValid = 1'b1; doneKind = k; doneLine = ln; doneReq = q;
    @(negedge clk);
    doneValid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R9 respValid after reset", respValid, 0);
    check("R9 blockReq after reset", blockReq, 0);
    check("R9 unblockReq after reset", unblockReq, 0);
    issue(3'd4, LA, 2'd0);
    check("R9 SC without LL valid", respValid, 1);
    check("R9 SC without LL fails", respPass, 0);
  endtask

  task automatic t_ll_sc();
    issue(3'd3, LA, 2'd1);
    check("R5 LL reports pass", respPass, 1);
    issue(3'd4, LA, 2'd1);
    check("R1 SC after LL passes", respPass, 1);
    issue(3'd4, LA, 2'd1);
    check("R3 second SC fails", respPass, 0);
  endtask

  task automatic t_wrong_req();
    issue(3'd3, LA, 2'd0);
    idle();
    issue(3'd4, LA, 2'd2);
    check("R2 SC by other requester fails", respPass, 0);
    issue(3'd4, LA, 2'd0);
    check("R3 failed SC cleared other owner", respPass, 0);
  endtask

  task automatic t_wrong_line();
    issue(3'd3, LA, 2'd0);
    issue(3'd4, LB, 2'd0);
    check("R2 SC on other line fails", respPass, 0);
    issue(3'd4, LA, 2'd0);
    check("R3 SC on other line kept reservation", respPass, 1);
  endtask

  task automatic t_store();
    issue(3'd3, LA, 2'd1);
    issue(3'd0, LA, 2'd2);
    check("R5 store reports pass", respPass, 1);
    issue(3'd4, LA, 2'd1);
    check("R4 other requester store keeps reservation", respPass, 1);
    issue(3'd3, LA, 2'd1);
    issue(3'd0, LB, 2'd1);
    issue(3'd4, LA, 2'd1);
    check("R4 own store to other line keeps reservation", respPass, 1);
    issue(3'd3, LA, 2'd1);
    issue(3'd0, LA, 2'd1);
    issue(3'd4, LA, 2'd1);
    check("R4 own store clears reservation", respPass, 0);
  endtask

  task automatic t_rmw();
    issue(3'd1, LA, 2'd0);
    check("R6 RMW read raises block", blockReq, 1);
    check("R6 RMW read no unblock", unblockReq, 0);
    check("R6 block line", ctrlLine, LA);
    check("R5 RMW read pass", respPass, 1);
    idle();
    check("R6 block is a pulse", blockReq, 0);
    check("R8 respValid single cycle", respValid, 0);
    issue(3'd2, LB, 2'd0);
    check("R6 RMW write raises unblock", unblockReq, 1);
    check("R6 RMW write no block", blockReq, 0);
    check("R6 unblock line", ctrlLine, LB);
    issue(3'd3, LB, 2'd3);
    issue(3'd2, LB, 2'd3);
    issue(3'd4, LB, 2'd3);
    check("R4 own RMW write clears reservation", respPass, 0);
  endtask

  task automatic t_overwrite();
    issue(3'd3, LA, 2'd2);
    issue(3'd3, LB, 2'd2);
    issue(3'd4, LA, 2'd2);
    check("R7 old reservation replaced", respPass, 0);
    issue(3'd4, LB, 2'd2);
    check("R7 new reservation holds", respPass, 1);
  endtask

  task automatic t_reserved();
    issue(3'd3, LA, 2'd0);
    issue(3'd5, LA, 2'd0);
    check("R8 kind 5 no response", respValid, 0);
    check("R8 kind 5 no block", blockReq, 0);
    issue(3'd7, LA, 2'd0);
    check("R8 kind 7 no unblock", unblockReq, 0);
    issue(3'd4, LA, 2'd0);
    check("R8 reserved kinds kept reservation", respPass, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ll_sc();
    t_wrong_req();
    t_wrong_line();
    t_store();
    t_rmw();
    t_overwrite();
    t_reserved();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule